// File: doc/BRIEF.md
# Destination Ring Completion Writer

This block is the receive half of a copy engine. The host keeps a ring of empty receive descriptors in memory. Each descriptor holds a buffer address and a byte count that the host has cleared to zero. The host then moves the write index forward to hand those descriptors to the engine. When an inbound transfer arrives, the block takes the descriptor at its own read index and streams the data into that buffer through a write handshake. It then writes the number of bytes it received back into the descriptor, and only after that does it step the read index and pulse completion.

A nonzero byte count in a descriptor tells the host that the entry is finished, so the block never writes a count of zero. A transfer may arrive as several gathered pieces. Together they fill one buffer and produce one completion. The ring size is a power of two set through a size register, and every index wraps by masking with the size minus one.

Top module: `dring_writer`

## Requirements
- R1: After reset both indices read back as 0, the ring holds 2**IDX_W entries, `inReady`, `cmplPulse` and `ovfErr` are low.
- R2: The number of posted descriptors is (write index − read index) masked with the ring mask. While it is zero, `inReady` stays low and no beat is taken, until a write-index update posts a buffer.
- R3: For each transfer, the descriptor at the read index is read, and each stored beat is written to the buffer address plus the running byte offset, in arrival order.
- R4: Beats up to and including the one with `inLast` form one transfer and give exactly one `cmplPulse`. A beat's `inBytes` code n means n bytes, and the code 0 means BEAT_BYTES bytes.
- R5: The stored byte count, never zero, is written to the descriptor at the read index one cycle before `cmplPulse`. The read index readback advances at the end of the `cmplPulse` cycle.
- R6: The read index advances as (index + 1) AND mask, so it wraps at the configured ring size.
- R7: A write-index update whose masked value equals the read index that holds after the current cycle is ignored. This covers the case where the read index is advancing in that same cycle. Any other update is taken.
- R8: A beat that would push the stored count above MAX_BYTES is taken from the stream but dropped: no buffer write, no count change. It sets `ovfErr`, which stays set until reset.
- R9: A size write (`sizeLog2`, ring of 2**sizeLog2 entries) is taken only when the engine is idle, and it clears both indices. When the engine is busy, the size write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sizeWe | input | 1 | Ring size register write strobe |
| sizeLog2 | input | LOG_W | Log2 of the ring entry count |
| wrIdxWe | input | 1 | Host write index update strobe |
| wrIdxIn | input | IDX_W | New host write index |
| rdIdxOut | output | IDX_W | Read index readback |
| wrIdxOut | output | IDX_W | Write index readback |
| descEn | output | 1 | Descriptor RAM access enable |
| descWe | output | 1 | Descriptor byte-count write |
| descIdx | output | IDX_W | Descriptor RAM entry |
| descWrLen | output | LEN_W | Byte count written back |
| descRdBuf | input | ADDR_W | Buffer address, one cycle after a read |
| inValid | input | 1 | Inbound beat valid |
| inReady | output | 1 | Inbound beat accepted |
| inData | input | DATA_W | Inbound beat data |
| inBytes | input | BCODE_W | Beat byte code (0 = full beat) |
| inLast | input | 1 | Last beat of the transfer |
| bufWrValid | output | 1 | Buffer write request |
| bufWrReady | input | 1 | Buffer write accepted |
| bufWrAddr | output | ADDR_W | Buffer byte address |
| bufWrData | output | DATA_W | Buffer write data |
| bufWrBytes | output | BCODE_W | Buffer write byte code |
| cmplPulse | output | 1 | One-cycle completion |
| ovfErr | output | 1 | Sticky overflow error |

## Verification
The host's write-index update and the engine's read-index advance can land in the same cycle. The write-index acceptance rule must then compare against the read index that is about to take effect. The bench provokes this by issuing a write-index update in exactly the cycle where `cmplPulse` is high. In one run the value equals the incoming read index and must be refused. In another it lies one further and must be taken. The write-index readback judges both cases, and so does whether the following transfers still complete.

// File: rtl/dring_pkg.sv
package dring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_STREAM,
    ST_WRLEN,
    ST_ADV
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic sizeTake;
    logic clrCnt;
    logic loadBase;
    logic addBeat;
    logic flagOvf;
    logic advance;
  } ctlStrobes_t;
endpackage

// File: rtl/dring_datapath.sv
module dring_datapath
  import dring_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 16,
  parameter int LOG_W      = 3,
  parameter int BCODE_W    = 2,
  parameter int LEN_W      = 5,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BYTES  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [LOG_W-1:0]  sizeLog2,
  input  logic              wrIdxWe,
  input  logic [IDX_W-1:0]  wrIdxIn,
  input  logic [ADDR_W-1:0] descRdBuf,
  input  logic [BCODE_W-1:0] inBytes,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              ringEmpty,
  output logic              beatFits,
  output logic [LEN_W-1:0]  byteCnt,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              ovf
);
  localparam int SUM_W = LEN_W + 1;

  function automatic logic [IDX_W-1:0] maskOf(input int unsigned lg);
    logic [IDX_W-1:0] m;
    for (int i = 0; i < IDX_W; i++) m[i] = (i < lg);
    return m;
  endfunction

  logic [IDX_W-1:0]  mask;
  logic [ADDR_W-1:0] base;
  logic [IDX_W-1:0]  rdInc, rdNext, wrCand;
  logic [LEN_W-1:0]  beatLen;
  logic [SUM_W-1:0]  sumLen;

  always_comb begin
    rdInc     = (rdIdx + 1'b1) & mask;
    rdNext    = strb.advance ? rdInc : rdIdx;
    wrCand    = wrIdxIn & mask;
    ringEmpty = (wrIdx == rdIdx);
    beatLen   = (inBytes == '0) ? LEN_W'(BEAT_BYTES) : LEN_W'(inBytes);
    sumLen    = SUM_W'(byteCnt) + SUM_W'(beatLen);
    beatFits  = (sumLen <= SUM_W'(MAX_BYTES));
    bufAddr   = base + ADDR_W'(byteCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mask    <= maskOf(IDX_W);
      rdIdx   <= '0;
      wrIdx   <= '0;
      base    <= '0;
      byteCnt <= '0;
      ovf     <= 1'b0;
    end else begin
      if (strb.sizeTake) begin
        mask  <= maskOf(int'(sizeLog2));
        rdIdx <= '0;
        wrIdx <= '0;
      end else begin
        if (strb.advance) rdIdx <= rdInc;
        if (wrIdxWe && (wrCand != rdNext)) wrIdx <= wrCand;
      end
      if (strb.loadBase) base <= descRdBuf;
      if (strb.clrCnt) byteCnt <= '0;
      else if (strb.addBeat) byteCnt <= sumLen[LEN_W-1:0];
      if (strb.flagOvf) ovf <= 1'b1;
    end
  end

  // R5: a completion never reports an empty transfer
  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> (byteCnt != '0));
  // R5: the read index moves only after an advance or a size reload
  assert_rd_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdx != $past(rdIdx)) |-> ($past(strb.advance) || $past(strb.sizeTake)));
  // R7: a write index change never lands on the read index
  assert_wr_not_rd_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((wrIdx != $past(wrIdx)) && !$past(strb.sizeTake)) |-> (wrIdx != rdIdx));
  // R8: overflow flag is sticky, count never exceeds the limit
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> ovf);
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= LEN_W'(MAX_BYTES));
endmodule

// File: rtl/dring_control.sv
module dring_control
  import dring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sizeWe,
  input  logic        ringEmpty,
  input  logic        beatFits,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        bufWrReady,
  output ctlStrobes_t strb,
  output logic        inReady,
  output logic        bufWrValid,
  output logic        descEn,
  output logic        descWe,
  output logic        cmplPulse
);
  ctlState_t state, nxt;

  always_comb begin
    strb       = '0;
    inReady    = 1'b0;
    bufWrValid = 1'b0;
    descEn     = 1'b0;
    descWe     = 1'b0;
    cmplPulse  = 1'b0;
    nxt        = state;
    case (state)
      ST_IDLE: begin
        if (sizeWe) strb.sizeTake = 1'b1;
        else if (!ringEmpty) begin
          descEn      = 1'b1;
          strb.clrCnt = 1'b1;
          nxt         = ST_FETCH;
        end
      end
      ST_FETCH: begin
        strb.loadBase = 1'b1;
        nxt           = ST_STREAM;
      end
      ST_STREAM: begin
        inReady    = beatFits ? bufWrReady : 1'b1;
        bufWrValid = inValid && beatFits;
        if (inValid && inReady) begin
          strb.addBeat = beatFits;
          strb.flagOvf = !beatFits;
          if (inLast) nxt = ST_WRLEN;
        end
      end
      ST_WRLEN: begin
        descEn = 1'b1;
        descWe = 1'b1;
        nxt    = ST_ADV;
      end
      ST_ADV: begin
        cmplPulse    = 1'b1;
        strb.advance = 1'b1;
        nxt          = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nxt;
  end

  // R2: no beat is taken while nothing is posted
  assert_bp_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !ringEmpty);
  // R4: completion is a single-cycle pulse
  assert_single_cmpl_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmplPulse |=> !cmplPulse);
  // R5: byte-count write is followed by the completion
  assert_len_before_idx_R5: assert property (@(posedge clk) disable iff (!rstN)
    descWe |=> cmplPulse);
endmodule

// File: rtl/dring_writer.sv
module dring_writer
  import dring_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 16,
  parameter int BEAT_BYTES = 4,
  parameter int MAX_BYTES  = 16,
  localparam int DATA_W    = 8 * BEAT_BYTES,
  localparam int BCODE_W   = $clog2(BEAT_BYTES),
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int LOG_W     = $clog2(IDX_W + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sizeWe,
  input  logic [LOG_W-1:0]   sizeLog2,
  input  logic               wrIdxWe,
  input  logic [IDX_W-1:0]   wrIdxIn,
  output logic [IDX_W-1:0]   rdIdxOut,
  output logic [IDX_W-1:0]   wrIdxOut,
  output logic               descEn,
  output logic               descWe,
  output logic [IDX_W-1:0]   descIdx,
  output logic [LEN_W-1:0]   descWrLen,
  input  logic [ADDR_W-1:0]  descRdBuf,
  input  logic               inValid,
  output logic               inReady,
  input  logic [DATA_W-1:0]  inData,
  input  logic [BCODE_W-1:0] inBytes,
  input  logic               inLast,
  output logic               bufWrValid,
  input  logic               bufWrReady,
  output logic [ADDR_W-1:0]  bufWrAddr,
  output logic [DATA_W-1:0]  bufWrData,
  output logic [BCODE_W-1:0] bufWrBytes,
  output logic               cmplPulse,
  output logic               ovfErr
);
  ctlStrobes_t strb;
  logic ringEmpty, beatFits;
  logic [LEN_W-1:0] byteCnt;

  dring_control u_ctl (
    .clk(clk), .rstN(rstN), .sizeWe(sizeWe), .ringEmpty(ringEmpty),
    .beatFits(beatFits), .inValid(inValid), .inLast(inLast),
    .bufWrReady(bufWrReady), .strb(strb), .inReady(inReady),
    .bufWrValid(bufWrValid), .descEn(descEn), .descWe(descWe),
    .cmplPulse(cmplPulse)
  );

  dring_datapath #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .LOG_W(LOG_W), .BCODE_W(BCODE_W),
    .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES), .MAX_BYTES(MAX_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeLog2(sizeLog2),
    .wrIdxWe(wrIdxWe), .wrIdxIn(wrIdxIn), .descRdBuf(descRdBuf),
    .inBytes(inBytes), .rdIdx(rdIdxOut), .wrIdx(wrIdxOut),
    .ringEmpty(ringEmpty), .beatFits(beatFits), .byteCnt(byteCnt),
    .bufAddr(bufWrAddr), .ovf(ovfErr)
  );

  assign descIdx    = rdIdxOut;
  assign descWrLen  = byteCnt;
  assign bufWrData  = inData;
  assign bufWrBytes = inBytes;
endmodule

// File: tb/dring_writer_tb.sv
module dring_writer_tb;
  localparam int IDX_W = 4, ADDR_W = 16, BEAT_BYTES = 4, MAX_BYTES = 16;
  localparam int DATA_W = 32, BCODE_W = 2, LEN_W = 5, LOG_W = 3;
  localparam int ENTRIES = 1 << IDX_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic sizeWe = 0; logic [LOG_W-1:0] sizeLog2 = '0;
  logic wrIdxWe = 0; logic [IDX_W-1:0] wrIdxIn = '0;
  logic [IDX_W-1:0] rdIdxOut, wrIdxOut, descIdx;
  logic descEn, descWe; logic [LEN_W-1:0] descWrLen;
  logic [ADDR_W-1:0] descRdBuf;
  logic inValid = 0, inLast = 0, inReady; logic [DATA_W-1:0] inData = '0;
  logic [BCODE_W-1:0] inBytes = '0;
  logic bufWrValid, bufWrReady; logic [ADDR_W-1:0] bufWrAddr;
  logic [DATA_W-1:0] bufWrData; logic [BCODE_W-1:0] bufWrBytes;
  logic cmplPulse, ovfErr;

  always #5 clk = ~clk;

  dring_writer u_dut (
    .clk(clk), .rstN(rstN), .sizeWe(sizeWe), .sizeLog2(sizeLog2),
    .wrIdxWe(wrIdxWe), .wrIdxIn(wrIdxIn), .rdIdxOut(rdIdxOut), .wrIdxOut(wrIdxOut),
    .descEn(descEn), .descWe(descWe), .descIdx(descIdx), .descWrLen(descWrLen),
    .descRdBuf(descRdBuf), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inBytes(inBytes), .inLast(inLast), .bufWrValid(bufWrValid),
    .bufWrReady(bufWrReady), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .bufWrBytes(bufWrBytes), .cmplPulse(cmplPulse), .ovfErr(ovfErr)
  );

  // descriptor memory model
  logic [ADDR_W-1:0] memBuf [ENTRIES];
  logic [LEN_W-1:0]  memLen [ENTRIES];
  logic clrEn = 0; logic [IDX_W-1:0] clrIdx = '0;
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) memLen[i] <= '0;
      descRdBuf <= '0;
    end else begin
      if (clrEn) memLen[clrIdx] <= '0;
      if (descEn && descWe) memLen[descIdx] <= descWrLen;
      if (descEn && !descWe) descRdBuf <= memBuf[descIdx];
    end
  end

  always @(negedge clk) bufWrReady <= ($urandom % 4) != 0;

  // buffer write monitor (R3)
  int monChk = 0, monBad = 0, monTotal = 0, monStart = 0, cmplCnt = 0;
  int monBase = 0;
  always @(posedge clk) begin
    if (rstN && cmplPulse) cmplCnt++;
    if (rstN && bufWrValid && bufWrReady) begin
      monChk++;
      if (bufWrAddr != ADDR_W'(monBase + (monTotal - monStart))) begin
        monBad++;
        $display("FAIL R3 buffer address actual=%0h expected=%0h", bufWrAddr,
                 ADDR_W'(monBase + (monTotal - monStart)));
      end
      monTotal += (bufWrBytes == 0) ? BEAT_BYTES : int'(bufWrBytes);
    end
  end

  int nChecks = 0, nFail = 0;
  int shRd = 0, shWr = 0, shMask = ENTRIES - 1;
  bit expOvfEver = 0;
  int codeArr [8];

  task automatic chkEq(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrPulse(int v);
    @(negedge clk); wrIdxWe = 1; wrIdxIn = IDX_W'(v);
    @(negedge clk); wrIdxWe = 0;
  endtask

  task automatic sizePulse(int lg);
    @(negedge clk); sizeWe = 1; sizeLog2 = LOG_W'(lg);
    @(negedge clk); sizeWe = 0;
  endtask

  task automatic postBufs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); clrEn = 1; clrIdx = IDX_W'((shWr + i) & shMask);
    end
    @(negedge clk); clrEn = 0;
    shWr = (shWr + n) & shMask;
    wrPulse(shWr);
  endtask

  task automatic sendXfer(int nBeats, int collWr, string req);
    int idx, expLen, c0, startTot, waitN, bl;
    bit hs, gotCmpl;
    idx = shRd; expLen = 0; c0 = cmplCnt;
    for (int b = 0; b < nBeats; b++) begin
      bl = (codeArr[b] == 0) ? BEAT_BYTES : codeArr[b];
      if (expLen + bl <= MAX_BYTES) expLen += bl; else expOvfEver = 1;
    end
    @(negedge clk);
    startTot = monTotal; monStart = monTotal; monBase = int'(memBuf[idx]);
    for (int b = 0; b < nBeats; b++) begin
      if (b > 0) @(negedge clk);
      inValid = 1; inBytes = BCODE_W'(codeArr[b]); inLast = (b == nBeats - 1);
      inData = $urandom;
      forever begin
        #4; hs = inReady;
        @(posedge clk);
        if (hs) break;
        @(negedge clk);
      end
    end
    @(negedge clk); inValid = 0; inLast = 0;
    gotCmpl = 0; waitN = 0;
    while (!gotCmpl && waitN < 40) begin
      if (cmplPulse) gotCmpl = 1; else begin @(negedge clk); waitN++; end
    end
    chkEq({req, " R4 completion seen"}, int'(gotCmpl), 1);
    // R5: length already in memory, index not yet moved
    chkEq({req, " R5 descriptor length"}, int'(memLen[idx]), expLen);
    chkEq({req, " R5 read index before advance"}, int'(rdIdxOut), idx);
    if (collWr >= 0) begin wrIdxWe = 1; wrIdxIn = IDX_W'(collWr); end
    @(negedge clk); wrIdxWe = 0;
    shRd = (shRd + 1) & shMask;
    chkEq({req, " R6 read index after advance"}, int'(rdIdxOut), shRd);
    chkEq({req, " R3 bytes stored"}, monTotal - startTot, expLen);
    repeat (3) @(negedge clk);
    chkEq({req, " R4 single completion"}, cmplCnt - c0, 1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", (nChecks - nFail) + (monChk - monBad),
             nChecks + monChk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("%0d/%0d checks passed", (nChecks - nFail) + (monChk - monBad),
             nChecks + monChk + 1);
    $finish;
  end

  initial begin
    bit bad;
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) memBuf[i] = ADDR_W'(16'h1000 + i * 16'h100);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chkEq("R1 read index", int'(rdIdxOut), 0);
    chkEq("R1 write index", int'(wrIdxOut), 0);
    chkEq("R1 inReady", int'(inReady), 0);
    chkEq("R1 ovfErr", int'(ovfErr), 0);
    chkEq("R1 cmplPulse", int'(cmplPulse), 0);

    // R2 back-pressure with empty ring
    inValid = 1; inBytes = 1; inLast = 1; bad = 0;
    repeat (20) begin
      @(negedge clk); #4;
      if (inReady || cmplPulse) bad = 1;
    end
    @(negedge clk); inValid = 0; inLast = 0;
    chkEq("R2 no acceptance while empty", int'(bad), 0);

    // directed transfers, default ring
    postBufs(3);
    chkEq("R2 write index after post", int'(wrIdxOut), 3);
    codeArr[0] = 1; sendXfer(1, -1, "single");
    codeArr[0] = 0; codeArr[1] = 2; codeArr[2] = 3; sendXfer(3, -1, "R4 gather");
    codeArr[0] = 0; sendXfer(1, -1, "R4 full beat code");
    chkEq("R8 no overflow yet", int'(ovfErr), 0);

    // R8 overflow: six full beats into a 16 byte buffer
    postBufs(1);
    for (int b = 0; b < 6; b++) codeArr[b] = 0;
    sendXfer(6, -1, "R8 overflow");
    chkEq("R8 sticky flag", int'(ovfErr), 1);

    // R9 size change in idle
    sizePulse(2); shMask = 3; shRd = 0; shWr = 0;
    chkEq("R9 read index cleared", int'(rdIdxOut), 0);
    chkEq("R9 write index cleared", int'(wrIdxOut), 0);
    postBufs(3);
    for (int k = 0; k < 3; k++) begin codeArr[0] = k + 1; sendXfer(1, -1, "R6 small ring"); end
    postBufs(2);
    codeArr[0] = 2; sendXfer(1, -1, "R6 wrap");
    codeArr[0] = 3; sendXfer(1, -1, "R6 wrap");
    chkEq("R6 wrapped read index", int'(rdIdxOut), 1);

    // R9 size write while busy is ignored
    postBufs(1);
    repeat (4) @(negedge clk);
    sizePulse(4);
    chkEq("R9 busy size ignored", int'(wrIdxOut), 2);
    codeArr[0] = 1; sendXfer(1, -1, "R9 busy");

    // R7 write index reaching read index is refused
    postBufs(3);
    wrPulse(2);
    chkEq("R7 full-ring write refused", int'(wrIdxOut), 1);
    for (int k = 0; k < 3; k++) begin codeArr[0] = 2; sendXfer(1, -1, "R7 full ring"); end

    // R7 collision with read index advance
    postBufs(2);
    codeArr[0] = 1; sendXfer(1, 2, "R7 collide refuse");
    chkEq("R7 collision refused", int'(wrIdxOut), 3);
    codeArr[0] = 1; sendXfer(1, 0, "R7 collide accept");
    chkEq("R7 collision accepted", int'(wrIdxOut), 0);
    shWr = 0;
    codeArr[0] = 3; sendXfer(1, -1, "R7 drain");

    // constrained random on the full ring
    sizePulse(4); shMask = ENTRIES - 1; shRd = 0; shWr = 0;
    for (int t = 0; t < 40; t++) begin
      int nb;
      if (((shWr - shRd) & shMask) == 0) postBufs(1 + int'($urandom % shMask));
      nb = 1 + int'($urandom % 6);
      for (int b = 0; b < nb; b++) codeArr[b] = int'($urandom % 4);
      sendXfer(nb, -1, "R6 random");
    end
    chkEq("R8 sticky after random", int'(ovfErr), int'(expOvfEver));
    summary();
    $finish;
  end
endmodule